// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the arbitration and in-service core of an eight-input interrupt controller. It keeps a request vector, a mask vector and an in-service vector, together with a movable pointer that names the current lowest-priority input. Every cycle it works out which input should be signalled next. It raises a single interrupt line and later retires the in-service state on end-of-interrupt (EOI) commands. The block supports rotating priority, automatic end-of-interrupt, a special mask mode and a nested mode that keeps a cascaded input from locking itself out.

Requests arrive already conditioned. `req_set_i` and `req_clr_i` are per-input strobes from the trigger logic. `trig_level_i` marks the inputs that are level-triggered. An acknowledge names the input being serviced. A command port carries EOI, rotate and set-priority operations. A poll path lets software read the selected input and acknowledge it in one access.

The signalling state machine has two states. In `ST_QUIET` no interrupt is outstanding. In `ST_SIGNALLED` the interrupt line is high and the block waits for an acknowledge. There are two transitions. RAISE goes from `ST_QUIET` to `ST_SIGNALLED` when an eligible input exists and no acknowledge arrives in that cycle. TAKE goes from `ST_SIGNALLED` to `ST_QUIET` on any acknowledge, whether explicit or made by a poll read.

Top module: `irq_prio_core`

## Requirements
- R1: After reset:
  - the request and in-service vectors are 0x00;
  - the mask is 0xFF;
  - the lowest-priority pointer is 7;
  - `intr_o` is low, `pend_valid_o` is low and `poll_data_o` is 0x00.
- R2: Pending selection visits the inputs in the order L+1, L+2, ... modulo 8, where L is the pointer. It stops with no result at the first input whose in-service bit is set. Otherwise it reports, in `pend_pin_o`, the first input that is requested (bit set in `irr_o`) and not masked (bit clear in `imr_o`). `pend_valid_o` is high only when such an input is found.
- R3: While special mask mode is on, in-service bits play no part in pending selection. The mode is set by `smm_we_i` together with `smm_val_i`.
- R4: While `cfg_sfnm_i` is high, the in-service bit of input 2 does not stop the pending scan.
- R5: A non-specific EOI clears the first in-service bit in scan order. A non-specific EOI is `cmd_valid_i` with `cmd_eoi_i`=1 and `cmd_specific_i`=0. In special mask mode it skips in-service bits whose mask bit is set. With no eligible bit it changes nothing.
- R6: A specific EOI clears the in-service bit numbered by `cmd_level_i`. A specific EOI is `cmd_eoi_i`=1 with `cmd_specific_i`=1.
- R7: Every command loads the rotate flag from `cmd_rotate_i`. An EOI with `cmd_rotate_i`=1 moves the pointer to the input it cleared. A command with `cmd_eoi_i`=0, `cmd_specific_i`=1 and `cmd_rotate_i`=1 loads the pointer from `cmd_level_i`.
- R8: An acknowledge of input p has three effects:
  - it clears request bit p only if `trig_level_i[p]` is 0;
  - without automatic EOI (`cfg_aeoi_i`=0) it sets in-service bit p;
  - with automatic EOI it leaves the in-service bits unchanged, and if the rotate flag is set it moves the pointer to p.
- R9: `intr_o` rises one cycle after a cycle in which it was low, an eligible input existed and no acknowledge arrived. It falls one cycle after an acknowledge. While high, it does not react to new requests.
- R10: Poll read behaviour:
  - After `poll_arm_i`, `poll_data_o` shows 0x80 OR the selected input, or 0x00 if no input is eligible.
  - A `poll_rd_i` while armed acknowledges the shown input and disarms the poll.
  - While disarmed, `poll_data_o` is 0x00.
- R11: When an acknowledge and an EOI arrive in the same cycle, the acknowledge is applied first. The EOI then sees the in-service bit that the acknowledge set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| cfg_aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| cfg_sfnm_i | input | 1 | Nested mode that ignores in-service bit 2 |
| trig_level_i | input | 8 | Per-input level-trigger flag |
| req_set_i | input | 8 | Per-input request set strobes |
| req_clr_i | input | 8 | Per-input request clear strobes |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 8 | New mask value |
| smm_we_i | input | 1 | Special mask mode write enable |
| smm_val_i | input | 1 | Special mask mode value |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_eoi_i | input | 1 | Command is an EOI |
| cmd_specific_i | input | 1 | Command names an input |
| cmd_rotate_i | input | 1 | Command rotate flag |
| cmd_level_i | input | 3 | Input named by the command |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_pin_i | input | 3 | Acknowledged input |
| poll_arm_i | input | 1 | Arm the poll path |
| poll_rd_i | input | 1 | Poll read strobe |
| intr_o | output | 1 | Interrupt line |
| pend_valid_o | output | 1 | An input is eligible |
| pend_pin_o | output | 3 | Selected input |
| poll_data_o | output | 8 | Poll result |
| irr_o | output | 8 | Request vector |
| isr_o | output | 8 | In-service vector |
| imr_o | output | 8 | Mask vector |
| lowprio_o | output | 3 | Lowest-priority pointer |

## Verification
A stale in-service bit, or a pointer left in the wrong place, appears at once on `pend_pin_o` and `pend_valid_o`, because selection is combinational over the registered state. A wrong flag state appears on `intr_o` on the cycle after the acknowledge or request that should have moved it. The bench therefore reads `isr_o`, `irr_o` and `lowprio_o` directly after every acknowledge and command. It sweeps every in-service pattern against several request patterns under each mode combination, and compares the chosen input with an arithmetic model of the scan order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic {
        ST_QUIET,
        ST_SIGNALLED
    } sig_state_e;

    localparam int POLL_W = 8;
endpackage

// File: rtl/irq_rr_scan.sv
// Round-robin scan starting one past the lowest-priority index.
module irq_rr_scan #(
    parameter int NUM       = 8,
    parameter int IDX_W     = 3,
    parameter bit USE_BLOCK = 1'b1
) (
    input  logic [NUM-1:0]   cand_i,
    input  logic [NUM-1:0]   block_i,
    input  logic [IDX_W-1:0] low_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [NUM-1:0] blk_eff;

    generate
        if (USE_BLOCK) begin : g_block
            assign blk_eff = block_i;
        end else begin : g_noblock
            assign blk_eff = '0;
        end
    endgenerate

    always_comb begin
        logic             stop;
        logic [IDX_W-1:0] p;
        hit_o = 1'b0;
        idx_o = '0;
        stop  = 1'b0;
        p     = '0;
        for (int k = 0; k < NUM; k++) begin
            p = low_i + IDX_W'(k + 1);
            if (!stop) begin
                if (blk_eff[p]) begin
                    stop = 1'b1;
                end else if (cand_i[p]) begin
                    hit_o = 1'b1;
                    idx_o = p;
                    stop  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_reg_update.sv
// Next-state of request, in-service, pointer and rotate flag.
// Order inside one cycle: acknowledge, then command, then request strobes.
module irq_reg_update #(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   irr_i,
    input  logic [NUM-1:0]   isr_i,
    input  logic [NUM-1:0]   imr_i,
    input  logic [IDX_W-1:0] low_i,
    input  logic             rot_i,
    input  logic             smm_i,
    input  logic             aeoi_i,
    input  logic [NUM-1:0]   trig_level_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    input  logic [NUM-1:0]   req_set_i,
    input  logic [NUM-1:0]   req_clr_i,
    input  logic             cmd_valid_i,
    input  logic             cmd_eoi_i,
    input  logic             cmd_specific_i,
    input  logic             cmd_rotate_i,
    input  logic [IDX_W-1:0] cmd_level_i,
    output logic [NUM-1:0]   irr_o,
    output logic [NUM-1:0]   isr_o,
    output logic [IDX_W-1:0] low_o,
    output logic             rot_o
);
    logic [NUM-1:0]   irr_a;
    logic [NUM-1:0]   isr_a;
    logic [IDX_W-1:0] low_a;
    logic [NUM-1:0]   eoi_cand;
    logic             eoi_hit;
    logic [IDX_W-1:0] eoi_idx;

    // Stage 1: acknowledge
    always_comb begin
        irr_a = irr_i;
        isr_a = isr_i;
        low_a = low_i;
        if (ack_i) begin
            if (!trig_level_i[ack_idx_i]) begin
                irr_a[ack_idx_i] = 1'b0;
            end
            if (aeoi_i) begin
                if (rot_i) begin
                    low_a = ack_idx_i;
                end
            end else begin
                isr_a[ack_idx_i] = 1'b1;
            end
        end
    end

    assign eoi_cand = isr_a & ~(smm_i ? imr_i : '0);

    irq_rr_scan #(
        .NUM       (NUM),
        .IDX_W     (IDX_W),
        .USE_BLOCK (1'b0)
    ) i_eoi_scan (
        .cand_i  (eoi_cand),
        .block_i ('0),
        .low_i   (low_a),
        .hit_o   (eoi_hit),
        .idx_o   (eoi_idx)
    );

    // Stage 2: command, stage 3: request strobes
    always_comb begin
        isr_o = isr_a;
        low_o = low_a;
        rot_o = rot_i;
        if (cmd_valid_i) begin
            rot_o = cmd_rotate_i;
            if (cmd_eoi_i) begin
                if (cmd_specific_i) begin
                    isr_o[cmd_level_i] = 1'b0;
                    if (cmd_rotate_i) begin
                        low_o = cmd_level_i;
                    end
                end else if (eoi_hit) begin
                    isr_o[eoi_idx] = 1'b0;
                    if (cmd_rotate_i) begin
                        low_o = eoi_idx;
                    end
                end
            end else if (cmd_specific_i && cmd_rotate_i) begin
                low_o = cmd_level_i;
            end
        end
        irr_o = (irr_a & ~req_clr_i) | req_set_i;
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int CASCADE_PIN = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_n_i,
    input  logic                        cfg_aeoi_i,
    input  logic                        cfg_sfnm_i,
    input  logic [NUM_PINS-1:0]         trig_level_i,
    input  logic [NUM_PINS-1:0]         req_set_i,
    input  logic [NUM_PINS-1:0]         req_clr_i,
    input  logic                        mask_we_i,
    input  logic [NUM_PINS-1:0]         mask_wdata_i,
    input  logic                        smm_we_i,
    input  logic                        smm_val_i,
    input  logic                        cmd_valid_i,
    input  logic                        cmd_eoi_i,
    input  logic                        cmd_specific_i,
    input  logic                        cmd_rotate_i,
    input  logic [$clog2(NUM_PINS)-1:0] cmd_level_i,
    input  logic                        ack_valid_i,
    input  logic [$clog2(NUM_PINS)-1:0] ack_pin_i,
    input  logic                        poll_arm_i,
    input  logic                        poll_rd_i,
    output logic                        intr_o,
    output logic                        pend_valid_o,
    output logic [$clog2(NUM_PINS)-1:0] pend_pin_o,
    output logic [POLL_W-1:0]           poll_data_o,
    output logic [NUM_PINS-1:0]         irr_o,
    output logic [NUM_PINS-1:0]         isr_o,
    output logic [NUM_PINS-1:0]         imr_o,
    output logic [$clog2(NUM_PINS)-1:0] lowprio_o
);
    localparam int PIN_W    = $clog2(NUM_PINS);
    localparam int POLL_PAD = POLL_W - 1 - PIN_W;
    localparam logic [NUM_PINS-1:0] CASC_BIT = NUM_PINS'(1) << CASCADE_PIN;

    sig_state_e          state_q, state_d;
    logic [NUM_PINS-1:0] irr_q, isr_q, imr_q;
    logic [PIN_W-1:0]    low_q;
    logic                rot_q, smm_q, poll_armed_q;

    logic [NUM_PINS-1:0] irr_d, isr_d;
    logic [PIN_W-1:0]    low_d;
    logic                rot_d;
    logic [NUM_PINS-1:0] pend_cand, pend_block;
    logic                pend_hit;
    logic [PIN_W-1:0]    pend_idx;
    logic                poll_take, ack_any;
    logic [PIN_W-1:0]    ack_idx;

    // Pending selection
    assign pend_cand  = irr_q & ~imr_q;
    assign pend_block = smm_q ? '0 : (isr_q & ~(cfg_sfnm_i ? CASC_BIT : '0));

    irq_rr_scan #(
        .NUM       (NUM_PINS),
        .IDX_W     (PIN_W),
        .USE_BLOCK (1'b1)
    ) i_pend_scan (
        .cand_i  (pend_cand),
        .block_i (pend_block),
        .low_i   (low_q),
        .hit_o   (pend_hit),
        .idx_o   (pend_idx)
    );

    // Acknowledge sources: explicit strobe wins over a poll read
    assign poll_take = poll_rd_i && poll_armed_q && pend_hit && !ack_valid_i;
    assign ack_any   = ack_valid_i || poll_take;
    assign ack_idx   = ack_valid_i ? ack_pin_i : pend_idx;

    irq_reg_update #(
        .NUM   (NUM_PINS),
        .IDX_W (PIN_W)
    ) i_update (
        .irr_i          (irr_q),
        .isr_i          (isr_q),
        .imr_i          (imr_q),
        .low_i          (low_q),
        .rot_i          (rot_q),
        .smm_i          (smm_q),
        .aeoi_i         (cfg_aeoi_i),
        .trig_level_i   (trig_level_i),
        .ack_i          (ack_any),
        .ack_idx_i      (ack_idx),
        .req_set_i      (req_set_i),
        .req_clr_i      (req_clr_i),
        .cmd_valid_i    (cmd_valid_i),
        .cmd_eoi_i      (cmd_eoi_i),
        .cmd_specific_i (cmd_specific_i),
        .cmd_rotate_i   (cmd_rotate_i),
        .cmd_level_i    (cmd_level_i),
        .irr_o          (irr_d),
        .isr_o          (isr_d),
        .low_o          (low_d),
        .rot_o          (rot_d)
    );

    // Register file
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            irr_q        <= '0;
            isr_q        <= '0;
            imr_q        <= '1;
            low_q        <= PIN_W'(NUM_PINS - 1);
            rot_q        <= 1'b0;
            smm_q        <= 1'b0;
            poll_armed_q <= 1'b0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            low_q <= low_d;
            rot_q <= rot_d;
            if (mask_we_i) begin
                imr_q <= mask_wdata_i;
            end
            if (smm_we_i) begin
                smm_q <= smm_val_i;
            end
            if (poll_arm_i) begin
                poll_armed_q <= 1'b1;
            end else if (poll_rd_i) begin
                poll_armed_q <= 1'b0;
            end
        end
    end

    // Signalling state register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions RAISE and TAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:     if (pend_hit && !ack_any) state_d = ST_SIGNALLED;
            ST_SIGNALLED: if (ack_any)              state_d = ST_QUIET;
            default:      state_d = ST_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        intr_o       = (state_q == ST_SIGNALLED);
        pend_valid_o = pend_hit;
        pend_pin_o   = pend_idx;
        poll_data_o  = (poll_armed_q && pend_hit) ? {1'b1, {POLL_PAD{1'b0}}, pend_idx} : '0;
        irr_o        = irr_q;
        isr_o        = isr_q;
        imr_o        = imr_q;
        lowprio_o    = low_q;
    end

    // Assertions
    AST_ACK_DROPS_INTR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ack_any |=> !intr_o); // R9
    AST_RAISE_FOLLOWS_PEND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!intr_o && pend_valid_o && !ack_any) |=> intr_o); // R9
    AST_PEND_IS_CANDIDATE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pend_valid_o |-> (irr_o[pend_pin_o] && !imr_o[pend_pin_o])); // R2
    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ack_valid_i && !trig_level_i[ack_pin_i] && !req_set_i[ack_pin_i])
        |=> !irr_o[$past(ack_pin_i)]); // R8
    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cfg_aeoi_i && ack_valid_i && !isr_o[ack_pin_i]) |=> !isr_o[$past(ack_pin_i)]); // R8
    AST_SETPRIO_LOADS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cmd_valid_i && !cmd_eoi_i && cmd_specific_i && cmd_rotate_i)
        |=> (lowprio_o == $past(cmd_level_i))); // R7
    AST_POLL_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (poll_rd_i && !poll_arm_i) |=> (poll_data_o == '0)); // R10
endmodule

// File: tb/test_irq_prio_core.sv
module test_irq_prio_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_aeoi = 1'b0, cfg_sfnm = 1'b0;
    logic [7:0] trig_level = '0, req_set = '0, req_clr = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       smm_we = 1'b0, smm_val = 1'b0;
    logic       cmd_valid = 1'b0, cmd_eoi = 1'b0, cmd_specific = 1'b0, cmd_rotate = 1'b0;
    logic [2:0] cmd_level = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_pin = '0;
    logic       poll_arm = 1'b0, poll_rd = 1'b0;
    logic       intr, pend_valid;
    logic [2:0] pend_pin, lowprio;
    logic [7:0] poll_data, irr, isr, imr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_core i_irq_prio_core (
        .clk_i(clk), .rst_n_i(rst_n), .cfg_aeoi_i(cfg_aeoi), .cfg_sfnm_i(cfg_sfnm),
        .trig_level_i(trig_level), .req_set_i(req_set), .req_clr_i(req_clr),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .smm_we_i(smm_we), .smm_val_i(smm_val),
        .cmd_valid_i(cmd_valid), .cmd_eoi_i(cmd_eoi), .cmd_specific_i(cmd_specific),
        .cmd_rotate_i(cmd_rotate), .cmd_level_i(cmd_level), .ack_valid_i(ack_valid),
        .ack_pin_i(ack_pin), .poll_arm_i(poll_arm), .poll_rd_i(poll_rd), .intr_o(intr),
        .pend_valid_o(pend_valid), .pend_pin_o(pend_pin), .poll_data_o(poll_data),
        .irr_o(irr), .isr_o(isr), .imr_o(imr), .lowprio_o(lowprio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        req_set = '0; req_clr = '0; mask_we = 1'b0; smm_we = 1'b0;
        cmd_valid = 1'b0; ack_valid = 1'b0; poll_arm = 1'b0; poll_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    task automatic load_irr(input logic [7:0] p);
        req_clr = 8'hFF; req_set = p; tick();
    endtask

    task automatic load_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m; tick();
    endtask

    task automatic set_smm(input bit v);
        smm_we = 1'b1; smm_val = v; tick();
    endtask

    task automatic command(input bit e, input bit s, input bit r, input logic [2:0] l);
        cmd_valid = 1'b1; cmd_eoi = e; cmd_specific = s; cmd_rotate = r; cmd_level = l; tick();
    endtask

    task automatic build_isr(input logic [7:0] v);
        for (int k = 0; k < 8; k++) begin
            if (v[k]) begin
                ack_valid = 1'b1; ack_pin = 3'(k); tick();
            end
        end
    endtask

    // Expected selection per R2/R3/R4; -1 means none eligible
    function automatic int m_pend(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                                  input int low, input bit smm, input bit sfnm);
        logic [7:0] blk;
        blk = smm ? 8'h00 : (s & ~(sfnm ? 8'h04 : 8'h00));
        for (int k = 1; k <= 8; k++) begin
            int p;
            p = (low + k) % 8;
            if (blk[p]) return -1;
            if (r[p] && !m[p]) return p;
        end
        return -1;
    endfunction

    // Expected in-service bit cleared by a non-specific EOI per R5
    function automatic int m_top(input logic [7:0] s, input logic [7:0] m, input int low, input bit smm);
        for (int k = 1; k <= 8; k++) begin
            int p;
            p = (low + k) % 8;
            if (s[p] && !(smm && m[p])) return p;
        end
        return -1;
    endfunction

    task automatic chk_pend(input string tag, input int e);
        chk(tag, int'(pend_valid), (e >= 0) ? 1 : 0);
        if (e >= 0) chk(tag, int'(pend_pin), e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] irr_pats [8];
        irr_pats = '{8'hFF, 8'h55, 8'hAA, 8'h81, 8'h10, 8'h0C, 8'h40, 8'h03};
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 irr", int'(irr), 0);
        chk("R1 isr", int'(isr), 0);
        chk("R1 imr", int'(imr), 8'hFF);
        chk("R1 lowprio", int'(lowprio), 7);
        chk("R1 intr", int'(intr), 0);
        chk("R1 pend_valid", int'(pend_valid), 0);
        chk("R1 poll_data", int'(poll_data), 0);

        // R2: request sweep under every pointer; R7 set-priority
        load_mask(8'h00);
        for (int l = 0; l < 8; l++) begin
            command(1'b0, 1'b1, 1'b1, 3'(l));
            chk("R7 set-priority", int'(lowprio), l);
            for (int p = 0; p < 256; p++) begin
                load_irr(8'(p));
                chk_pend("R2 request sweep", m_pend(8'(p), 8'h00, 8'h00, l, 1'b0, 1'b0));
            end
        end
        // R2: mask sweep
        command(1'b0, 1'b1, 1'b1, 3'd7);
        for (int m = 0; m < 256; m++) begin
            load_mask(8'(m));
            load_irr(8'hA5);
            chk_pend("R2 mask sweep", m_pend(8'hA5, 8'(m), 8'h00, 7, 1'b0, 1'b0));
        end

        // R2/R3/R4: in-service sweep under each mode
        for (int s = 0; s < 256; s++) begin
            do_reset();
            load_mask(8'h00);
            build_isr(8'(s));
            chk("R8 isr build", int'(isr), s);
            for (int j = 0; j < 8; j++) begin
                load_irr(irr_pats[j]);
                for (int mode = 0; mode < 4; mode++) begin
                    cfg_sfnm = mode[1];
                    set_smm(mode[0]);
                    chk_pend(mode[0] ? "R3 smm sweep" : (mode[1] ? "R4 sfnm sweep" : "R2 isr sweep"),
                             m_pend(irr_pats[j], 8'h00, 8'(s), 7, mode[0], mode[1]));
                end
                cfg_sfnm = 1'b0;
                set_smm(1'b0);
            end
        end

        // R5: non-specific EOI, pointer varied, with and without special mask
        for (int smm = 0; smm < 2; smm++) begin
            for (int s = 1; s < 256; s++) begin
                int t;
                do_reset();
                command(1'b0, 1'b1, 1'b1, 3'(s % 8));
                load_mask(smm ? 8'h3C : 8'h00);
                set_smm(smm[0]);
                build_isr(8'(s));
                command(1'b1, 1'b0, 1'b0, 3'd0);
                t = m_top(8'(s), smm ? 8'h3C : 8'h00, s % 8, smm[0]);
                chk("R5 non-specific EOI", int'(isr), (t >= 0) ? (s & ~(1 << t)) : s);
            end
        end

        // R7: rotating non-specific EOI
        do_reset();
        build_isr(8'h24);
        command(1'b1, 1'b0, 1'b1, 3'd0);
        chk("R7 rotate EOI isr", int'(isr), 8'h20);
        chk("R7 rotate EOI pointer", int'(lowprio), 2);
        command(1'b1, 1'b0, 1'b1, 3'd0);
        chk("R7 rotate EOI isr 2", int'(isr), 8'h00);
        chk("R7 rotate EOI pointer 2", int'(lowprio), 5);

        // R6: specific EOI
        do_reset();
        build_isr(8'hFF);
        command(1'b1, 1'b1, 1'b0, 3'd5);
        chk("R6 specific EOI", int'(isr), 8'hDF);
        chk("R6 pointer kept", int'(lowprio), 7);
        command(1'b1, 1'b1, 1'b1, 3'd1);
        chk("R6 specific EOI rotate", int'(isr), 8'hDD);
        chk("R7 specific EOI pointer", int'(lowprio), 1);

        // R8: level vs edge acknowledge
        do_reset();
        load_mask(8'h00);
        trig_level = 8'h10;
        load_irr(8'h30);
        ack_valid = 1'b1; ack_pin = 3'd4; tick();
        chk("R8 level ack irr", int'(irr), 8'h30);
        chk("R8 level ack isr", int'(isr), 8'h10);
        ack_valid = 1'b1; ack_pin = 3'd5; tick();
        chk("R8 edge ack irr", int'(irr), 8'h10);
        chk("R8 edge ack isr", int'(isr), 8'h30);
        trig_level = 8'h00;

        // R8: automatic EOI
        do_reset();
        cfg_aeoi = 1'b1;
        load_irr(8'h08);
        ack_valid = 1'b1; ack_pin = 3'd3; tick();
        chk("R8 aeoi isr", int'(isr), 0);
        chk("R8 aeoi irr", int'(irr), 0);
        chk("R8 aeoi no rotate", int'(lowprio), 7);
        command(1'b0, 1'b0, 1'b1, 3'd0);
        load_irr(8'h40);
        ack_valid = 1'b1; ack_pin = 3'd6; tick();
        chk("R8 aeoi rotate isr", int'(isr), 0);
        chk("R8 aeoi rotate pointer", int'(lowprio), 6);
        cfg_aeoi = 1'b0;

        // R9: interrupt flag timing
        do_reset();
        load_mask(8'h00);
        load_irr(8'h02);
        chk("R9 not yet raised", int'(intr), 0);
        tick();
        chk("R9 raised", int'(intr), 1);
        req_set = 8'h01; tick();
        chk("R9 held while raised", int'(intr), 1);
        ack_valid = 1'b1; ack_pin = 3'd0; tick();
        chk("R9 dropped on ack", int'(intr), 0);
        chk("R9 ack isr", int'(isr), 8'h01);
        command(1'b1, 1'b0, 1'b0, 3'd0);
        chk("R9 quiet after EOI cycle", int'(intr), 0);
        tick();
        chk("R9 raised again", int'(intr), 1);

        // R10: poll
        do_reset();
        load_mask(8'h00);
        poll_arm = 1'b1; tick();
        chk("R10 poll empty", int'(poll_data), 0);
        load_irr(8'h48);
        chk("R10 poll value", int'(poll_data), 8'h83);
        poll_rd = 1'b1; tick();
        chk("R10 poll ack isr", int'(isr), 8'h08);
        chk("R10 poll ack irr", int'(irr), 8'h40);
        chk("R10 poll disarmed", int'(poll_data), 0);
        poll_arm = 1'b1; tick();
        chk("R10 poll blocked", int'(poll_data), 0);

        // R11: acknowledge applied before EOI in the same cycle
        do_reset();
        load_mask(8'h00);
        build_isr(8'h40);
        load_irr(8'h10);
        ack_valid = 1'b1; ack_pin = 3'd4;
        cmd_valid = 1'b1; cmd_eoi = 1'b1; cmd_specific = 1'b0; cmd_rotate = 1'b0;
        tick();
        chk("R11 ack then EOI isr", int'(isr), 8'h40);
        chk("R11 ack then EOI irr", int'(irr), 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule